// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block collects 64 level-sensitive interrupt sources into two request lines for a processor: a normal request and a fast request. For each source it keeps a pending bit, an enable bit, a routing bit that selects the normal or the fast line, and a 4-bit priority. The normal line is gated by a programmable 5-bit threshold. The fast line is raised whenever any enabled fast-routed source is pending.

Software reaches the block through a simple 32-bit register port with word addressing. The port has no wait states. Read data is combinational while a read is selected, and writes take effect at the clock edge that ends the access. Enable bits can be changed a half at a time, or set and cleared by writing a source number. Pending bits can be forced from software. Two vector registers name the winning source and acknowledge it: the acknowledge clears the winner's pending bit at the same edge that ends the read. A source whose input is still high sets its pending bit again on the following edge.

Top module: `vic_regbank`

## Requirements
- R1: A source input sampled high at a clock edge sets its pending bit. A source input that was high at the previous edge and is low now clears its pending bit. A source input with either of these events wins over a software force to the same bit.
- R2: Word 1 holds the normal threshold. Only its low 5 bits are stored and read back.
- R3: A write to word 2 sets the enable bit numbered by data[5:0]. A write to word 3 clears that bit. Both words read as zero.
- R4: Words 4 and 5 access enable bits 63..32 and 31..0. Words 6 and 7 do the same for the routing bits, where 1 routes a source to the fast line.
- R5: Words 8..15 hold priorities, eight sources per word, in reverse order: word 15 holds sources 0..7 and word 8 holds sources 56..63. Source 8g+k uses bits [4k+3:4k] of word 15-g.
- R6: irq_fast is high exactly when some source is pending, enabled and routed fast.
- R7: irq_norm is high when some source is pending, enabled and routed normal, and in addition either the threshold is 0x1F or that source's priority is strictly greater than the threshold.
- R8: A read of word 16 returns (source << 16) | priority for the pending, enabled, normal-routed source with the highest priority. On a tie the higher-numbered source wins. The read clears that pending bit. With no candidate the read returns 0xFFFFFFFF.
- R9: A read of word 17 returns the number of the lowest-numbered pending, enabled, fast-routed source and clears its pending bit. With no candidate the read returns 0xFFFFFFFF.
- R10: After reset the pending, enable, routing and priority state is all zero, the threshold is 0x1F, and both request lines are low.
- R11: Words 18 and 19 return pending bits 63..32 and 31..0, and writes to them are ignored. Writes to words 20 and 21 replace pending bits 63..32 and 31..0, and both words read as zero.
- R12: Words 22 and 23 return pending&enabled&normal-routed bits (high half, then low half). Words 24 and 25 return the same for fast-routed sources.
- R13: A vector acknowledge clears the pending bit at the edge that ends the read, and this wins over a high input at that edge. If the input is still high at the next edge, the bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 64 | Source interrupt levels |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected, zero otherwise |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The acknowledge properties assume that a vector read lasts a single cycle and that only one register access is made per cycle. Otherwise a held read would acknowledge several sources in turn. The bench therefore pulses bus_sel for exactly one cycle per access and changes src_lvl only on falling edges. The check that a high input sets its bit is armed only once a full cycle has passed since reset, so source levels held during reset are never judged. The stimulus drives most pending state through the force words, with the inputs held low, so that level events do not override the forced values.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  localparam int NSRC       = 64;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int PRIO_W     = 4;
  localparam int MASK_W     = 5;
  localparam int IDX_W      = $clog2(NSRC);
  localparam int HALF_W     = NSRC / 2;
  localparam int PER_WORD   = DATA_W / PRIO_W;
  localparam int PRIO_WORDS = NSRC / PER_WORD;
  localparam int GRP_W      = $clog2(PRIO_WORDS);
  localparam int VEC_IDX_LSB = 16;

  localparam logic [MASK_W-1:0] MASK_OFF = '1;

  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ENSET  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ENCLR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ENHI   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ENLO   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_TYHI   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_TYLO   = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_PRFIRST = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_PRLAST = ADDR_W'(8 + PRIO_WORDS - 1);
  localparam logic [ADDR_W-1:0] A_NVEC   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_FVEC   = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] A_RAWHI  = ADDR_W'(18);
  localparam logic [ADDR_W-1:0] A_RAWLO  = ADDR_W'(19);
  localparam logic [ADDR_W-1:0] A_FRCHI  = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] A_FRCLO  = ADDR_W'(21);
  localparam logic [ADDR_W-1:0] A_NPHI   = ADDR_W'(22);
  localparam logic [ADDR_W-1:0] A_NPLO   = ADDR_W'(23);
  localparam logic [ADDR_W-1:0] A_FPHI   = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] A_FPLO   = ADDR_W'(25);

  localparam logic [DATA_W-1:0] VEC_NONE = '1;

  // Status word of the normal vector register: source number above, priority below.
  function automatic logic [DATA_W-1:0] norm_vec_word(input logic [IDX_W-1:0] idx,
                                                      input logic [PRIO_W-1:0] prio);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VEC_IDX_LSB +: IDX_W] = idx;
    w[PRIO_W-1:0] = prio;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] fast_vec_word(input logic [IDX_W-1:0] idx);
    return DATA_W'(idx);
  endfunction

  // Priority group held by a priority word: the order is reversed.
  function automatic logic [GRP_W-1:0] prio_group(input logic [ADDR_W-1:0] addr);
    return GRP_W'(int'(A_PRLAST) - int'(addr));
  endfunction

  function automatic logic [NSRC-1:0] one_hot(input logic [IDX_W-1:0] idx);
    logic [NSRC-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/vic_pend_bits.sv
`timescale 1ns/1ps
module vic_pend_bits
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              frc_hi_we,
  input  logic              frc_lo_we,
  input  logic [DATA_W-1:0] frc_data,
  input  logic [NSRC-1:0]   ack_clr,
  output logic [NSRC-1:0]   pend
);
  logic [NSRC-1:0] src_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    localparam int HALF = i / DATA_W;
    localparam int POS  = i % DATA_W;
    logic frc_we;
    if (HALF == 0) begin : g_lo
      assign frc_we = frc_lo_we;
    end else begin : g_hi
      assign frc_we = frc_hi_we;
    end

    // Acknowledge, then level events, then software force.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i]  <= 1'b0;
        src_q[i] <= 1'b0;
      end else begin
        src_q[i] <= src_lvl[i];
        if (ack_clr[i])       pend[i] <= 1'b0;
        else if (src_lvl[i])  pend[i] <= 1'b1;
        else if (src_q[i])    pend[i] <= 1'b0;
        else if (frc_we)      pend[i] <= frc_data[POS];
      end
    end
  end
endmodule

// File: rtl/vic_norm_pick.sv
`timescale 1ns/1ps
module vic_norm_pick
  import vic_pkg::*;
(
  input  logic [NSRC-1:0]        flags,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [MASK_W-1:0]      thresh,
  output logic                   found,
  output logic [IDX_W-1:0]       win_idx,
  output logic [PRIO_W-1:0]      win_prio,
  output logic                   above
);
  // Highest priority wins; ">=" lets the higher number take a tie.
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (flags[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] >= win_prio)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // Independent reduction: any candidate strictly above the threshold.
  always_comb begin
    above = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (flags[i] && (MASK_W'(prio_flat[i*PRIO_W +: PRIO_W]) > thresh)) above = 1'b1;
    end
  end
endmodule

// File: rtl/vic_fast_pick.sv
`timescale 1ns/1ps
module vic_fast_pick
  import vic_pkg::*;
(
  input  logic [NSRC-1:0]  flags,
  output logic             found,
  output logic [IDX_W-1:0] win_idx
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (flags[i]) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_regbank.sv
`timescale 1ns/1ps
module vic_regbank
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_norm,
  output logic              irq_fast
);
  logic [NSRC-1:0]        pend;
  logic [NSRC-1:0]        en;
  logic [NSRC-1:0]        ty_fast;
  logic [MASK_W-1:0]      mask_q;
  logic [NSRC*PRIO_W-1:0] prio_flat;

  logic wr_en, rd_en, in_prio;
  logic [GRP_W-1:0] grp;
  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign in_prio = (bus_addr >= A_PRFIRST) && (bus_addr <= A_PRLAST);
  assign grp     = prio_group(bus_addr);

  logic [NSRC-1:0] norm_flags, fast_flags;
  assign norm_flags = pend & en & ~ty_fast;
  assign fast_flags = pend & en & ty_fast;

  logic              norm_found, norm_above, fast_found;
  logic [IDX_W-1:0]  norm_idx, fast_idx;
  logic [PRIO_W-1:0] norm_prio;

  vic_norm_pick u_norm (
    .flags    (norm_flags),
    .prio_flat(prio_flat),
    .thresh   (mask_q),
    .found    (norm_found),
    .win_idx  (norm_idx),
    .win_prio (norm_prio),
    .above    (norm_above)
  );

  vic_fast_pick u_fast (
    .flags  (fast_flags),
    .found  (fast_found),
    .win_idx(fast_idx)
  );

  // Acknowledge events, brought out for the checker.
  logic ack_norm, ack_fast;
  logic [NSRC-1:0] ack_clr;
  assign ack_norm = rd_en && (bus_addr == A_NVEC) && norm_found;
  assign ack_fast = rd_en && (bus_addr == A_FVEC) && fast_found;
  assign ack_clr  = (ack_norm ? one_hot(norm_idx) : '0) | (ack_fast ? one_hot(fast_idx) : '0);

  logic frc_hi_we, frc_lo_we;
  assign frc_hi_we = wr_en && (bus_addr == A_FRCHI);
  assign frc_lo_we = wr_en && (bus_addr == A_FRCLO);

  vic_pend_bits u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_lvl  (src_lvl),
    .frc_hi_we(frc_hi_we),
    .frc_lo_we(frc_lo_we),
    .frc_data (bus_wdata),
    .ack_clr  (ack_clr),
    .pend     (pend)
  );

  // Configuration registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= '0;
      ty_fast   <= '0;
      mask_q    <= MASK_OFF;
      prio_flat <= '0;
    end else if (wr_en) begin
      if (in_prio) begin
        prio_flat[int'(grp)*DATA_W +: DATA_W] <= bus_wdata;
      end else begin
        case (bus_addr)
          A_MASK:  mask_q <= bus_wdata[MASK_W-1:0];
          A_ENSET: en[bus_wdata[IDX_W-1:0]] <= 1'b1;
          A_ENCLR: en[bus_wdata[IDX_W-1:0]] <= 1'b0;
          A_ENHI:  en[NSRC-1:HALF_W] <= bus_wdata;
          A_ENLO:  en[HALF_W-1:0] <= bus_wdata;
          A_TYHI:  ty_fast[NSRC-1:HALF_W] <= bus_wdata;
          A_TYLO:  ty_fast[HALF_W-1:0] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // Read path.
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (in_prio) begin
        bus_rdata = prio_flat[int'(grp)*DATA_W +: DATA_W];
      end else begin
        case (bus_addr)
          A_MASK:  bus_rdata = DATA_W'(mask_q);
          A_ENHI:  bus_rdata = en[NSRC-1:HALF_W];
          A_ENLO:  bus_rdata = en[HALF_W-1:0];
          A_TYHI:  bus_rdata = ty_fast[NSRC-1:HALF_W];
          A_TYLO:  bus_rdata = ty_fast[HALF_W-1:0];
          A_NVEC:  bus_rdata = norm_found ? norm_vec_word(norm_idx, norm_prio) : VEC_NONE;
          A_FVEC:  bus_rdata = fast_found ? fast_vec_word(fast_idx) : VEC_NONE;
          A_RAWHI: bus_rdata = pend[NSRC-1:HALF_W];
          A_RAWLO: bus_rdata = pend[HALF_W-1:0];
          A_NPHI:  bus_rdata = norm_flags[NSRC-1:HALF_W];
          A_NPLO:  bus_rdata = norm_flags[HALF_W-1:0];
          A_FPHI:  bus_rdata = fast_flags[NSRC-1:HALF_W];
          A_FPLO:  bus_rdata = fast_flags[HALF_W-1:0];
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq_fast = |fast_flags;
  assign irq_norm = norm_found && ((mask_q == MASK_OFF) || norm_above);
endmodule

// File: rtl/vic_regbank_chk.sv
`timescale 1ns/1ps
module vic_regbank_chk
  import vic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_lvl,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_norm,
  input logic              irq_fast,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   en,
  input logic [MASK_W-1:0] mask_q,
  input logic              fast_found,
  input logic [IDX_W-1:0]  norm_idx,
  input logic [PRIO_W-1:0] norm_prio,
  input logic [IDX_W-1:0]  fast_idx,
  input logic              ack_norm,
  input logic              ack_fast,
  input logic [NSRC-1:0]   ack_clr
);
  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  p_src_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (($past(src_lvl) & ~$past(ack_clr) & ~pend) == '0));

  p_enset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_ENSET) |=> en[$past(bus_wdata[IDX_W-1:0])]);

  p_enclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_ENCLR) |=> !en[$past(bus_wdata[IDX_W-1:0])]);

  p_fast_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast == fast_found);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_norm && mask_q != MASK_OFF) |-> (MASK_W'(norm_prio) > mask_q));

  p_norm_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_norm |=> !pend[$past(norm_idx)]);

  p_fast_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fast |=> !pend[$past(fast_idx)]);

  p_fvec_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == A_FVEC && !irq_fast) |-> (bus_rdata == VEC_NONE));

  p_one_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ack_clr) <= 1);
endmodule

bind vic_regbank vic_regbank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_lvl   (src_lvl),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_norm  (irq_norm),
  .irq_fast  (irq_fast),
  .pend      (pend),
  .en        (en),
  .mask_q    (mask_q),
  .fast_found(fast_found),
  .norm_idx  (norm_idx),
  .norm_prio (norm_prio),
  .fast_idx  (fast_idx),
  .ack_norm  (ack_norm),
  .ack_fast  (ack_fast),
  .ack_clr   (ack_clr)
);

// File: tb/vic_regbank_tb_top.sv
`timescale 1ns/1ps
module vic_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_lvl;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_norm, irq_fast;

  always #2 clk = ~clk;

  vic_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_norm(irq_norm), .irq_fast(irq_fast)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic irq_chk(input string tag, input logic n, input logic f);
    @(negedge clk); #1;
    chk({tag, " irq_norm"}, {31'd0, irq_norm}, {31'd0, n});
    chk({tag, " irq_fast"}, {31'd0, irq_fast}, {31'd0, f});
  endtask

  task automatic t_reset;
    irq_chk("R10 reset", 1'b0, 1'b0);
    rd_chk("R10 threshold", 5'd1, 32'h1F);
    rd_chk("R10 enable hi", 5'd4, 32'h0);
    rd_chk("R10 enable lo", 5'd5, 32'h0);
    rd_chk("R10 type lo", 5'd7, 32'h0);
    rd_chk("R10 prio w15", 5'd15, 32'h0);
    rd_chk("R10 pending lo", 5'd19, 32'h0);
  endtask

  task automatic t_enable_num;
    wr(5'd2, 32'hFFFF_FF45);
    rd_chk("R3 set bit5", 5'd5, 32'h20);
    wr(5'd2, 32'd40);
    rd_chk("R3 set bit40", 5'd4, 32'h100);
    rd_chk("R3 set word reads 0", 5'd2, 32'h0);
    rd_chk("R3 clr word reads 0", 5'd3, 32'h0);
    wr(5'd3, 32'h0000_00C5);
    rd_chk("R3 clr bit5", 5'd5, 32'h0);
    wr(5'd3, 32'd40);
    rd_chk("R3 clr bit40", 5'd4, 32'h0);
  endtask

  task automatic t_halves;
    wr(5'd4, 32'hA5A5_0001);
    wr(5'd5, 32'h1234_5678);
    wr(5'd6, 32'h0000_00F0);
    rd_chk("R4 enable hi", 5'd4, 32'hA5A5_0001);
    rd_chk("R4 enable lo", 5'd5, 32'h1234_5678);
    rd_chk("R4 type hi", 5'd6, 32'h0000_00F0);
    rd_chk("R4 type lo", 5'd7, 32'h0);
    wr(5'd4, 32'h0); wr(5'd5, 32'h0); wr(5'd6, 32'h0);
  endtask

  task automatic t_pending;
    @(negedge clk); src_lvl[3] = 1'b1;
    rd_chk("R1 level sets", 5'd19, 32'h8);
    wr(5'd21, 32'h0);
    rd_chk("R1 high level beats force", 5'd19, 32'h8);
    @(negedge clk); src_lvl[3] = 1'b0;
    rd_chk("R1 falling clears", 5'd19, 32'h0);
    wr(5'd21, 32'h10);
    rd_chk("R11 force lo", 5'd19, 32'h10);
    wr(5'd20, 32'h8000_0001);
    rd_chk("R11 force hi", 5'd18, 32'h8000_0001);
    rd_chk("R11 force reads 0", 5'd20, 32'h0);
    wr(5'd18, 32'h0);
    rd_chk("R11 raw write ignored", 5'd18, 32'h8000_0001);
    wr(5'd20, 32'h0); wr(5'd21, 32'h0);
  endtask

  task automatic t_prio_and_vec;
    wr(5'd15, 32'h7654_3210);
    rd_chk("R5 word15", 5'd15, 32'h7654_3210);
    wr(5'd15, 32'h0);
    wr(5'd14, 32'h0000_0500);   // source 10 -> 5
    wr(5'd13, 32'h0005_0000);   // source 20 -> 5
    wr(5'd12, 32'h0200_0000);   // source 30 -> 2
    wr(5'd8,  32'h0009_0000);   // source 60 -> 9
    rd_chk("R5 word13", 5'd13, 32'h0005_0000);
    wr(5'd5, (32'd1 << 10) | (32'd1 << 20) | (32'd1 << 30));
    wr(5'd4, 32'h1000_0000);
    wr(5'd21, (32'd1 << 10) | (32'd1 << 20) | (32'd1 << 30));
    wr(5'd20, 32'h1000_0000);
    irq_chk("R7 open threshold", 1'b1, 1'b0);
    rd_chk("R12 normal view hi", 5'd22, 32'h1000_0000);
    rd_chk("R12 fast view lo", 5'd25, 32'h0);
    rd_chk("R8 top source 60", 5'd16, 32'h003C_0009);
    rd_chk("R8 tie to 20", 5'd16, 32'h0014_0005);
    rd_chk("R8 then 10", 5'd16, 32'h000A_0005);
    rd_chk("R8 then 30", 5'd16, 32'h001E_0002);
    rd_chk("R8 empty", 5'd16, 32'hFFFF_FFFF);
    irq_chk("R8 all acked", 1'b0, 1'b0);
  endtask

  task automatic t_gate;
    wr(5'd1, 32'hFFFF_FFE3);
    rd_chk("R2 five bits", 5'd1, 32'h3);
    wr(5'd21, 32'd1 << 30);      // source 30, priority 2
    wr(5'd1, 32'd2);
    irq_chk("R7 equal blocked", 1'b0, 1'b0);
    wr(5'd1, 32'd1);
    irq_chk("R7 above passes", 1'b1, 1'b0);
    wr(5'd1, 32'h1F);
    wr(5'd21, 32'h0);
    irq_chk("R7 no pending", 1'b0, 1'b0);
  endtask

  task automatic t_fast;
    wr(5'd4, 32'h0004_0100);     // sources 40 and 50
    wr(5'd6, 32'h0004_0100);
    wr(5'd20, 32'h0004_0100);
    irq_chk("R6 fast asserted", 1'b0, 1'b1);
    rd_chk("R12 fast view hi", 5'd24, 32'h0004_0100);
    rd_chk("R12 normal view hi", 5'd22, 32'h0);
    rd_chk("R8 none normal", 5'd16, 32'hFFFF_FFFF);
    rd_chk("R9 lowest 40", 5'd17, 32'd40);
    rd_chk("R9 then 50", 5'd17, 32'd50);
    rd_chk("R9 empty", 5'd17, 32'hFFFF_FFFF);
    irq_chk("R6 fast drops", 1'b0, 1'b0);
    wr(5'd21, 32'd1 << 10);
    rd_chk("R12 normal view lo", 5'd23, 32'h400);
    rd_chk("R12 fast view lo", 5'd25, 32'h0);
    rd_chk("R8 source 10", 5'd16, 32'h000A_0005);
  endtask

  task automatic t_repend;
    wr(5'd2, 32'd3);
    @(negedge clk); src_lvl[3] = 1'b1;
    rd_chk("R13 ack source 3", 5'd16, 32'h0003_0000);
    rd_chk("R13 cleared at ack edge", 5'd19, 32'h0);
    rd_chk("R13 re-set while high", 5'd19, 32'h8);
    @(negedge clk); src_lvl[3] = 1'b0;
    rd_chk("R13 falls", 5'd19, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; src_lvl = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_enable_num();
    t_halves();
    t_pending();
    t_prio_and_vec();
    t_gate();
    t_fast();
    t_repend();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule